// File: doc/BRIEF.md
# Sixteen-Line I/O Expander Register and Interrupt Core

This block is the register and pin-control core of a general purpose I/O expander with sixteen lines, split into two independent 8-bit ports. A host reaches its registers through a simple synchronous bus: a 4-bit register address, 8-bit write data, a write strobe, a read strobe and registered read data. For each port the block keeps a direction mask, an output latch, a read-polarity mask, a last-read input snapshot and an interrupt capture register. It drives per-pin output values and output enables, and it samples the pin inputs through a two-flop synchroniser.

When any pin configured as an input no longer matches the snapshot taken at the last read of its port, the block marks that port pending, freezes the synchronised port value into the capture register and pulls the shared active-low interrupt line low. A read of the port's input register clears the pending state and refreshes the snapshot. A separate comparator reports whether a 7-bit bus address matches the fixed device prefix followed by the 3-bit strap select. This lets up to eight such devices share one bus.

Top module: `gpio_expander_core`

## Requirements
- R1: After reset every direction register reads 0xFF, every output latch, polarity and capture register reads 0x00, all output enables are 0, and int_n is 1.
- R2: The register address holds the port index in bit 0 and the group in bits 3:1 (0 input, 1 output latch, 2 polarity, 3 direction, 4 capture). Writes to the output latch, polarity and direction groups take effect at the clock edge. Each reads back the written value. A pin's output enable is the inverse of its direction bit, and its output value is its output latch bit.
- R3: A read of the input group returns the pin value after a two-flop synchroniser, XOR the port's polarity mask. The value is presented on rd_data one cycle after the read strobe.
- R4: int_n goes low on the third rising clock edge after a change on an input-configured pin, counting the edge that first samples the pin. The edge that samples the pin is counted as the first of the three.
- R5: A change on a pin configured as an output (direction bit 0) never sets a port's interrupt.
- R6: When a port's interrupt is set, its capture register takes the synchronised port value of that cycle. It then keeps that value while further input changes occur, until the port is cleared and a new event happens.
- R7: Reading a port's input register clears that port's pending interrupt and makes the current synchronised value the new comparison snapshot. int_n returns to 1 once no port is pending.
- R8: The two ports are independent: reading port 0's input register does not clear a pending interrupt on port 1.
- R9: Writes to the input and capture groups have no effect on any register or on int_n.
- R10: addr_match is 1 exactly when bus_addr equals the 4-bit prefix 4'b0100 followed by dev_sel.
- R11: Reads of group codes 5 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr | input | 4 | Register address: group in bits 3:1, port in bit 0 |
| wr_data | input | 8 | Register write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_en |
| pins_in | input | 16 | Pin input levels, port 1 in the upper byte |
| pins_out | output | 16 | Pin output values |
| pins_oe | output | 16 | Pin output enables, 1 drives the pin |
| int_n | output | 1 | Active-low interrupt, 1 when released |
| dev_sel | input | 3 | Device address straps |
| bus_addr | input | 7 | Incoming 7-bit bus address to compare |
| addr_match | output | 1 | bus_addr matches this device |

## Verification
Every cycle, the assertions check the per-port interrupt state machine. A read always clears the pending flag. A pending flag is never raised without an unmasked mismatch in the cycle before. An unmasked mismatch with no read always raises it. A pending capture register stays frozen. The exact latency from a pin edge to int_n, the polarity applied to read data, the masking of output pins, the independence of the two ports, the ignored writes to read-only groups and the address comparator are shown only by the bench's scenarios, which compare port values against expectations derived from the register map.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int NUM_PORTS = 2;
  localparam int ADDR_W    = 4;

  typedef enum logic [2:0] {
    GRP_INPUT   = 3'd0,
    GRP_OUTPUT  = 3'd1,
    GRP_POLAR   = 3'd2,
    GRP_DIR     = 3'd3,
    GRP_CAPTURE = 3'd4
  } reg_group_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_out = stage2_q;
endmodule

// File: rtl/gpx_port.sv
module gpx_port #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_sync,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              wr_out,
  input  logic              wr_pol,
  input  logic              wr_dir,
  input  logic              rd_in,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] pol_q,
  output logic [PORT_W-1:0] cap_q,
  output logic              pend_q
);
  logic [PORT_W-1:0] snap_q;
  logic [PORT_W-1:0] dir_d, out_d, pol_d, cap_d, snap_d;
  logic              pend_d;
  logic [PORT_W-1:0] mismatch;

  // Only input-configured pins (direction bit 1) take part in the compare
  assign mismatch = (pin_sync ^ snap_q) & dir_q;

  always_comb begin
    dir_d  = wr_dir ? wr_data : dir_q;
    out_d  = wr_out ? wr_data : out_q;
    pol_d  = wr_pol ? wr_data : pol_q;
    snap_d = snap_q;
    cap_d  = cap_q;
    pend_d = pend_q;
    if (rd_in) begin
      snap_d = pin_sync;
      pend_d = 1'b0;
    end else if (!pend_q && (|mismatch)) begin
      pend_d = 1'b1;
      cap_d  = pin_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      out_q  <= '0;
      pol_q  <= '0;
      snap_q <= '0;
      cap_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      pol_q  <= pol_d;
      snap_q <= snap_d;
      cap_q  <= cap_d;
      pend_q <= pend_d;
    end
  end

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_in |=> !pend_q);

  assert_capture_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rd_in) |=> (pend_q && $stable(cap_q)));

  assert_change_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && (|mismatch) && !rd_in) |=> pend_q);

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(|((pin_sync ^ snap_q) & dir_q)));
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
  import gpx_pkg::*;
#(
  parameter int       PORT_W     = 8,
  parameter logic [3:0] DEV_PREFIX = 4'b0100
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [PORT_W-1:0]           wr_data,
  input  logic                        wr_en,
  input  logic                        rd_en,
  output logic [PORT_W-1:0]           rd_data,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_in,
  output logic [NUM_PORTS*PORT_W-1:0] pins_out,
  output logic [NUM_PORTS*PORT_W-1:0] pins_oe,
  output logic                        int_n,
  input  logic [2:0]                  dev_sel,
  input  logic [6:0]                  bus_addr,
  output logic                        addr_match
);
  localparam int PINS = NUM_PORTS * PORT_W;

  logic [PINS-1:0]   pins_sync;
  reg_group_e        grp;
  logic              port_sel;
  logic [NUM_PORTS-1:0][PORT_W-1:0] dir_a, out_a, pol_a, cap_a;
  logic [NUM_PORTS-1:0]             pend_a;
  logic [PORT_W-1:0] rd_mux;
  logic [PORT_W-1:0] rd_data_d;

  assign grp      = reg_group_e'(reg_addr[ADDR_W-1:1]);
  assign port_sel = reg_addr[0];

  gpx_sync #(.WIDTH(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pins_in),
    .d_out (pins_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = (port_sel == p[0]);

    gpx_port #(.PORT_W(PORT_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_sync (pins_sync[p*PORT_W +: PORT_W]),
      .wr_data  (wr_data),
      .wr_out   (wr_en && hit && (grp == GRP_OUTPUT)),
      .wr_pol   (wr_en && hit && (grp == GRP_POLAR)),
      .wr_dir   (wr_en && hit && (grp == GRP_DIR)),
      .rd_in    (rd_en && hit && (grp == GRP_INPUT)),
      .dir_q    (dir_a[p]),
      .out_q    (out_a[p]),
      .pol_q    (pol_a[p]),
      .cap_q    (cap_a[p]),
      .pend_q   (pend_a[p])
    );

    assign pins_out[p*PORT_W +: PORT_W] = out_a[p];
    assign pins_oe[p*PORT_W +: PORT_W]  = ~dir_a[p];
  end

  always_comb begin
    case (grp)
      GRP_INPUT:   rd_mux = pins_sync[port_sel*PORT_W +: PORT_W] ^ pol_a[port_sel];
      GRP_OUTPUT:  rd_mux = out_a[port_sel];
      GRP_POLAR:   rd_mux = pol_a[port_sel];
      GRP_DIR:     rd_mux = dir_a[port_sel];
      GRP_CAPTURE: rd_mux = cap_a[port_sel];
      default:     rd_mux = '0;
    endcase
  end

  assign rd_data_d = rd_en ? rd_mux : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_data_d;
    end
  end

  assign int_n      = ~(|pend_a);
  assign addr_match = (bus_addr == {DEV_PREFIX, dev_sel});

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/gpio_expander_core_test.sv
`timescale 1ns/1ps
module gpio_expander_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic [7:0]  wr_data;
  logic        wr_en, rd_en;
  logic [7:0]  rd_data;
  logic [15:0] pins_in, pins_out, pins_oe;
  logic        int_n;
  logic [2:0]  dev_sel;
  logic [6:0]  bus_addr;
  logic        addr_match;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_expander_core uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .pins_in(pins_in),
    .pins_out(pins_out), .pins_oe(pins_oe), .int_n(int_n),
    .dev_sel(dev_sel), .bus_addr(bus_addr), .addr_match(addr_match)
  );

  // {pins_in, polarity (port1,port0), expected input reads (port1,port0)}
  localparam logic [47:0] VEC [6] = '{
    {16'h0001, 16'h0000, 16'h0001},
    {16'h1234, 16'h00FF, 16'h1234 ^ 16'h00FF},
    {16'hFFFF, 16'hFF00, 16'h00FF},
    {16'hA55A, 16'h0F0F, 16'hA55A ^ 16'h0F0F},
    {16'h0000, 16'hFFFF, 16'hFFFF},
    {16'h8001, 16'h8080, 16'h8001 ^ 16'h8080}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d, d2;
    reg_addr = '0; wr_data = '0; wr_en = 1'b0; rd_en = 1'b0;
    pins_in = '0; dev_sel = 3'd0; bus_addr = '0;
    do_reset();

    // R1: reset state
    check("R1 int_n", {15'd0, int_n}, 16'd1);
    check("R1 oe", pins_oe, 16'h0000);
    rd(4'd6, d); check("R1 dir0", {8'd0, d}, 16'h00FF);
    rd(4'd7, d); check("R1 dir1", {8'd0, d}, 16'h00FF);
    rd(4'd3, d); check("R1 out1", {8'd0, d}, 16'h0000);
    rd(4'd4, d); check("R1 pol0", {8'd0, d}, 16'h0000);
    rd(4'd9, d); check("R1 cap1", {8'd0, d}, 16'h0000);

    // R3 / R7: vector table, input reads with polarity
    foreach (VEC[i]) begin
      pins_in = VEC[i][47:32];
      wr(4'd4, VEC[i][23:16]);
      wr(4'd5, VEC[i][31:24]);
      repeat (4) @(negedge clk);
      rd(4'd0, d);
      rd(4'd1, d2);
      check("R3 in0", {8'd0, d}, {8'd0, VEC[i][7:0]});
      check("R3 in1", {8'd0, d2}, {8'd0, VEC[i][15:8]});
      @(negedge clk);
      check("R7 int released", {15'd0, int_n}, 16'd1);
    end
    wr(4'd4, 8'h00); wr(4'd5, 8'h00);
    pins_in = 16'h0000;
    repeat (4) @(negedge clk);
    rd(4'd0, d); rd(4'd1, d);
    @(negedge clk);

    // R4: latency, third edge after pin change
    pins_in = 16'h0004;
    @(negedge clk); @(negedge clk);
    check("R4 not yet", {15'd0, int_n}, 16'd1);
    @(negedge clk);
    check("R4 asserted", {15'd0, int_n}, 16'd0);
    // R6: capture holds through further changes
    pins_in = 16'h0006;
    repeat (4) @(negedge clk);
    rd(4'd8, d); check("R6 capture", {8'd0, d}, 16'h0004);
    // R9: writes to capture and input groups ignored
    wr(4'd8, 8'hEE); wr(4'd0, 8'h55);
    rd(4'd8, d); check("R9 capture kept", {8'd0, d}, 16'h0004);
    check("R9 int kept", {15'd0, int_n}, 16'd0);
    rd(4'd0, d); check("R7 in0", {8'd0, d}, 16'h0006);
    @(negedge clk);
    check("R7 cleared", {15'd0, int_n}, 16'd1);

    // R2: direction, output latch, enables
    wr(4'd6, 8'h0F); wr(4'd2, 8'hA5); wr(4'd3, 8'h3C);
    check("R2 oe", pins_oe, 16'h00F0);
    check("R2 out", pins_out, 16'h3CA5);
    rd(4'd6, d); check("R2 dir0 rb", {8'd0, d}, 16'h000F);
    rd(4'd3, d); check("R2 out1 rb", {8'd0, d}, 16'h003C);

    // R5: output-configured pin change masked
    pins_in = 16'h0086;
    repeat (5) @(negedge clk);
    check("R5 masked", {15'd0, int_n}, 16'd1);
    pins_in = 16'h0087;
    repeat (4) @(negedge clk);
    check("R5 input pin fires", {15'd0, int_n}, 16'd0);
    rd(4'd0, d);
    @(negedge clk);
    check("R7 cleared again", {15'd0, int_n}, 16'd1);

    // R8: ports independent
    pins_in = 16'h0187;
    repeat (4) @(negedge clk);
    check("R8 port1 fires", {15'd0, int_n}, 16'd0);
    rd(4'd0, d);
    @(negedge clk);
    check("R8 port1 still pending", {15'd0, int_n}, 16'd0);
    rd(4'd9, d); check("R8 cap1", {8'd0, d}, 16'h0001);
    rd(4'd1, d);
    @(negedge clk);
    check("R8 port1 cleared", {15'd0, int_n}, 16'd1);

    // R11: unused groups read zero
    rd(4'd12, d); check("R11 unused", {8'd0, d}, 16'h0000);

    // R10: address comparator
    dev_sel = 3'd5; bus_addr = 7'b0100101; #1;
    check("R10 match", {15'd0, addr_match}, 16'd1);
    bus_addr = 7'b0100100; #1;
    check("R10 low bits differ", {15'd0, addr_match}, 16'd0);
    bus_addr = 7'b1100101; #1;
    check("R10 prefix differs", {15'd0, addr_match}, 16'd0);

    // R1: reset mid-run restores defaults
    do_reset();
    check("R1 oe after reset", pins_oe, 16'h0000);
    check("R1 out after reset", pins_out, 16'h0000);
    rd(4'd8, d); check("R1 cap0 after reset", {8'd0, d}, 16'h0000);

    finish_run();
  end
endmodule